// File: doc/BRIEF.md
# Asynchronous SRAM Test Pattern Sequencer

This block sits on the tester side of a 4K x 4 asynchronous static RAM and runs a fixed self-test against it. It drives a 12-bit address and two active-low controls, chip-select and write-enable. Instead of one inout pin, the 4-bit data bus is split into an output value, a per-bit output enable and an input sample. The surrounding pad logic merges the three and supplies a pull-up on the wire. All pins are plain control and status signals. No streaming interface exists, so back-pressure never applies.

A pulse on `start` launches a run of 70 accesses. Each access lasts three vector cycles: an address cycle with both controls high, a data cycle, and a disable cycle with both controls high again. Write data is driven only during the data cycle of a write. Read data is sampled at a fixed tick inside the data cycle and compared against the expected nibble under a bit mask.

The run always completes. The first mismatch is recorded, together with its address, the expected nibble and the raw observed nibble. When the run ends, `done` rises.

Top module: `sram_pattern_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done` and `fail` are 0, both controls are high, `mem_dq_oe` is 0 and `mem_addr` is 0.
- R2: Every access takes three steps of CYCLE_TICKS clocks each: address, data, disable. In the address and disable steps both controls are high and `mem_dq_oe` is 0. The address is held through all three steps.
- R3: In the data step of a write, `mem_cs_n` and `mem_we_n` are both 0. `mem_dq_oe` equals the access mask and `mem_dq_out` carries the write value on the masked bits.
- R4: In the data step of a read, `mem_we_n` is 1 and `mem_dq_oe` is 0. `mem_dq_in` is compared under the mask only on tick SAMPLE_TICK of that step, counting from 0.
- R5: The order of the pattern phases is fixed:
  - a per-pin test (16 accesses),
  - pass one (26 accesses),
  - pass two (26 accesses),
  - a deselect check (2 accesses).
- R6: Both passes visit 13 addresses. Address k (k = 0..12) has its k low bits set and all other bits clear, so the walk runs 0x000, 0x001, 0x003 and so on up to 0xFFF. Each pass writes all 13 addresses in that order and then reads them back in the same order.
- R7: Pass one writes and expects these values, in walk order: 0, 1, 3, 7, F, E, C, 8, A, 2, 6, 2, 6 (hex).
- R8: Pass two writes and expects these values, in walk order: F, E, C, 8, 0, 1, 3, 7, 5, D, 9, D, 9 (hex).
- R9: The per-pin test takes data bits 0, 1, 2 and 3 in turn, all at address 0. For each bit it performs four accesses: write 0, read, write 1, read. Only that bit is driven and compared, so the mask is one-hot.
- R10: The deselect check first writes 0 to address 0 with all bits driven. It then performs a read data step with `mem_cs_n` high and `mem_we_n` high, and expects F on all four bits.
- R11: A mismatch on a compared bit sets `fail`. Only the first mismatch of a run loads `fail_addr`, `fail_exp` (the expected value) and `fail_obs` (the raw bus value). Later mismatches change none of them, and the run continues to the end.
- R12: After the last disable step `done` is 1 and the bus is quiet. A `start` pulse while idle or done begins a new run and clears `fail` and `done`. A `start` pulse during a run has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a run when idle or done |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has completed |
| mem_addr | output | 12 | RAM address |
| mem_cs_n | output | 1 | RAM chip-select, active low |
| mem_we_n | output | 1 | RAM write-enable, active low |
| mem_dq_out | output | 4 | Value driven onto the data bus |
| mem_dq_oe | output | 4 | Per-bit output enable for the data bus |
| mem_dq_in | input | 4 | Resolved data bus as seen at the pins |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | 12 | Address of the first mismatch |
| fail_exp | output | 4 | Expected value of the first mismatch |
| fail_obs | output | 4 | Observed bus value of the first mismatch |

## Verification
The hardest situation to reach from the ports is a first-failure record that must survive a later mismatch of its own run. A correct RAM never produces one. To reach it, the bench's memory model pins bit 2 low at two walk addresses: 0x00F fails in pass one and 0x0FF fails only in pass two. Only the first of these may be kept. A second fault run weakens the bus pull into a pull-down, so the deselect read sees zeros. Both fault runs are launched from the done state, which also checks that the flags are cleared on restart.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 4;
  localparam int WALK_LEN = ADDR_W + 1;
  localparam int PIN_ACC  = DATA_W * 4;
  localparam int PASS_ACC = 2 * WALK_LEN;
  localparam int NUM_ACC  = PIN_ACC + 2 * PASS_ACC + 2;
  localparam int IDX_W    = $clog2(NUM_ACC);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_DIS, ST_DONE} step_e;
  typedef enum logic [1:0] {PH_PIN, PH_PASS1, PH_PASS2, PH_DESEL} phase_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] mask;
    logic              is_write;
    logic              desel;
  } access_t;

  // k low bits set
  function automatic logic [ADDR_W-1:0] therm_addr(input int k);
    logic [ADDR_W-1:0] a;
    a = '0;
    for (int i = 0; i < ADDR_W; i++) if (i < k) a[i] = 1'b1;
    return a;
  endfunction

  function automatic logic [DATA_W-1:0] pass1_val(input int k);
    case (k)
      0: return 4'h0;  1: return 4'h1;  2: return 4'h3;  3: return 4'h7;
      4: return 4'hF;  5: return 4'hE;  6: return 4'hC;  7: return 4'h8;
      8: return 4'hA;  9: return 4'h2; 10: return 4'h6; 11: return 4'h2;
      default: return 4'h6;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] pass2_val(input int k);
    case (k)
      0: return 4'hF;  1: return 4'hE;  2: return 4'hC;  3: return 4'h8;
      4: return 4'h0;  5: return 4'h1;  6: return 4'h3;  7: return 4'h7;
      8: return 4'h5;  9: return 4'hD; 10: return 4'h9; 11: return 4'hD;
      default: return 4'h9;
    endcase
  endfunction
endpackage

// File: rtl/sps_step_timer.sv
module sps_step_timer #(
  parameter int CYCLE_TICKS = 200,
  parameter int SAMPLE_TICK = 180
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic step_end,
  output logic sample_hit
);
  localparam int TICK_W = (CYCLE_TICKS > 1) ? $clog2(CYCLE_TICKS) : 1;

  logic [TICK_W-1:0] tick;

  assign step_end   = (tick == TICK_W'(CYCLE_TICKS - 1));
  assign sample_hit = (tick == TICK_W'(SAMPLE_TICK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tick <= '0;
    else if (!run || step_end) tick <= '0;
    else                       tick <= tick + 1'b1;
  end

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tick) < CYCLE_TICKS); // R2
endmodule

// File: rtl/sps_access_rom.sv
module sps_access_rom
  import sps_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output access_t          acc,
  output phase_e           phase
);
  always_comb begin
    int ii;
    int k;
    int bit_i;
    int sub;
    ii    = int'(idx);
    acc   = '0;
    phase = PH_PIN;
    k     = 0;
    bit_i = 0;
    sub   = 0;
    if (ii < PIN_ACC) begin
      phase        = PH_PIN;
      bit_i        = ii / 4;
      sub          = ii % 4;
      acc.mask     = DATA_W'(1) << bit_i;
      acc.is_write = ((sub % 2) == 0);
      acc.data     = (sub >= 2) ? acc.mask : '0;
    end else if (ii < PIN_ACC + PASS_ACC) begin
      phase    = PH_PASS1;
      k        = ii - PIN_ACC;
      acc.mask = '1;
      if (k < WALK_LEN) begin
        acc.is_write = 1'b1;
      end else begin
        k = k - WALK_LEN;
      end
      acc.addr = therm_addr(k);
      acc.data = pass1_val(k);
    end else if (ii < PIN_ACC + 2 * PASS_ACC) begin
      phase    = PH_PASS2;
      k        = ii - PIN_ACC - PASS_ACC;
      acc.mask = '1;
      if (k < WALK_LEN) begin
        acc.is_write = 1'b1;
      end else begin
        k = k - WALK_LEN;
      end
      acc.addr = therm_addr(k);
      acc.data = pass2_val(k);
    end else if (ii == NUM_ACC - 2) begin
      phase        = PH_DESEL;
      acc.mask     = '1;
      acc.is_write = 1'b1;
    end else begin
      phase     = PH_DESEL;
      acc.mask  = '1;
      acc.data  = '1;
      acc.desel = 1'b1;
    end
  end
endmodule

// File: rtl/sps_fail_capture.sv
module sps_fail_capture
  import sps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] exp_val,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] bus,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_obs
);
  logic mismatch;
  assign mismatch = sample_en && (((bus ^ exp_val) & mask) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_obs  <= '0;
    end else if (clear) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_obs  <= '0;
    end else if (mismatch && !fail) begin
      fail      <= 1'b1;
      fail_addr <= addr;
      fail_exp  <= exp_val;
      fail_obs  <= bus;
    end
  end

  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clear) |=> (fail && $stable(fail_addr) && $stable(fail_obs))); // R11
  AST_FAIL_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(sample_en)); // R4
endmodule

// File: rtl/sram_pattern_seq.sv
module sram_pattern_seq
  import sps_pkg::*;
#(
  parameter int CYCLE_TICKS = 200,
  parameter int SAMPLE_TICK = 180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_obs
);
  step_e            state;
  logic [IDX_W-1:0] idx;
  access_t          acc;
  phase_e           phase;
  logic             step_end;
  logic             sample_hit;
  logic             launch;
  logic             sample_en;

  assign busy      = (state == ST_ADDR) || (state == ST_DATA) || (state == ST_DIS);
  assign done      = (state == ST_DONE);
  assign launch    = start && !busy;
  assign sample_en = (state == ST_DATA) && !acc.is_write && sample_hit;

  sps_step_timer #(.CYCLE_TICKS(CYCLE_TICKS), .SAMPLE_TICK(SAMPLE_TICK)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .step_end(step_end), .sample_hit(sample_hit));

  sps_access_rom u_rom (.idx(idx), .acc(acc), .phase(phase));

  sps_fail_capture u_cap (
    .clk(clk), .rst_n(rst_n), .clear(launch), .sample_en(sample_en),
    .addr(acc.addr), .exp_val(acc.data), .mask(acc.mask), .bus(mem_dq_in),
    .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_obs(fail_obs));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: if (start) begin
          state <= ST_ADDR;
          idx   <= '0;
        end
        ST_ADDR: if (step_end) state <= ST_DATA;
        ST_DATA: if (step_end) state <= ST_DIS;
        ST_DIS: if (step_end) begin
          if (idx == IDX_W'(NUM_ACC - 1)) state <= ST_DONE;
          else begin
            idx   <= idx + 1'b1;
            state <= ST_ADDR;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr   = acc.addr;
    mem_cs_n   = 1'b1;
    mem_we_n   = 1'b1;
    mem_dq_oe  = '0;
    mem_dq_out = '0;
    if (state == ST_DATA) begin
      if (acc.is_write) begin
        mem_cs_n   = 1'b0;
        mem_we_n   = 1'b0;
        mem_dq_oe  = acc.mask;
        mem_dq_out = acc.data & acc.mask;
      end else begin
        mem_cs_n = acc.desel;
      end
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA || state == ST_DIS) |-> $stable(mem_addr)); // R2
  AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe != '0) |-> (!mem_cs_n && !mem_we_n)); // R3
  AST_PIN_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PIN) |-> ($countones(mem_dq_oe) <= 1)); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_cs_n && mem_we_n && mem_dq_oe == '0)); // R12
  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R12
endmodule

// File: tb/tb_sram_pattern_seq.sv
module tb_sram_pattern_seq;
  localparam int CYC  = 20;
  localparam int SAMP = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, cs_n, we_n, fail;
  logic [11:0] addr, fail_addr;
  logic [3:0] dq_out, dq_oe, dq_in, fail_exp, fail_obs;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sram_pattern_seq #(.CYCLE_TICKS(CYC), .SAMPLE_TICK(SAMP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mem_addr(addr), .mem_cs_n(cs_n), .mem_we_n(we_n),
    .mem_dq_out(dq_out), .mem_dq_oe(dq_oe), .mem_dq_in(dq_in),
    .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_obs(fail_obs));

  // RAM model with pull on the undriven bus and optional stuck bit
  logic [3:0] ram [4096];
  bit fault_en = 1'b0;
  bit pull_up  = 1'b1;
  logic [3:0] rd_val;
  logic       ram_drv;

  always_comb begin
    rd_val = ram[addr];
    if (fault_en && (addr == 12'h00F || addr == 12'h0FF)) rd_val[2] = 1'b0;
    ram_drv = !cs_n && we_n;
    for (int i = 0; i < 4; i++)
      dq_in[i] = dq_oe[i] ? dq_out[i] : (ram_drv ? rd_val[i] : pull_up);
  end

  always @(posedge clk) if (!cs_n && !we_n) ram[addr] <= dq_in;

  typedef struct {
    logic [11:0] a;
    logic [3:0]  d;
    logic [3:0]  m;
    bit          wr;
    bit          ds;
  } item_t;
  item_t sb[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [11:0] a, input logic [3:0] d, input logic [3:0] m, input bit wr, input bit ds);
    item_t it;
    it.a = a; it.d = d; it.m = m; it.wr = wr; it.ds = ds;
    sb.push_back(it);
  endtask

  // Driver: expected access list from the requirements
  task automatic push_all();
    logic [3:0] t1 [13] = '{4'h0,4'h1,4'h3,4'h7,4'hF,4'hE,4'hC,4'h8,4'hA,4'h2,4'h6,4'h2,4'h6}; // R7
    logic [3:0] t2 [13] = '{4'hF,4'hE,4'hC,4'h8,4'h0,4'h1,4'h3,4'h7,4'h5,4'hD,4'h9,4'hD,4'h9}; // R8
    for (int b = 0; b < 4; b++) begin // R9
      logic [3:0] m;
      m = 4'(1 << b);
      push(12'h0, 4'h0, m, 1'b1, 1'b0);
      push(12'h0, 4'h0, m, 1'b0, 1'b0);
      push(12'h0, m,    m, 1'b1, 1'b0);
      push(12'h0, m,    m, 1'b0, 1'b0);
    end
    for (int p = 0; p < 2; p++) begin // R5 R6
      for (int rd = 0; rd < 2; rd++) begin
        for (int k = 0; k < 13; k++) begin
          logic [11:0] a;
          a = 12'((32'd1 << k) - 1);
          push(a, (p == 0) ? t1[k] : t2[k], 4'hF, rd == 0, 1'b0);
        end
      end
    end
    push(12'h0, 4'h0, 4'hF, 1'b1, 1'b0); // R10
    push(12'h0, 4'hF, 4'hF, 1'b0, 1'b1);
  endtask

  // Monitor: starts at the address step of the first access
  task automatic monitor();
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(addr == it.a, "R6 address", 32'(addr), 32'(it.a));
      check(cs_n && we_n && dq_oe == 4'h0, "R2 address step quiet", {cs_n, we_n, dq_oe}, 6'h30);
      repeat (CYC) @(negedge clk);
      repeat (SAMP) @(negedge clk);
      if (it.wr) begin
        check(!cs_n && !we_n, "R3 write controls", {cs_n, we_n}, 2'b00);
        check(dq_oe == it.m, "R3 R9 write enable mask", 32'(dq_oe), 32'(it.m));
        check((dq_out & it.m) == it.d, "R7 R8 write data", 32'(dq_out & it.m), 32'(it.d));
      end else begin
        check(cs_n == it.ds && we_n, "R4 R10 read controls", {cs_n, we_n}, {it.ds, 1'b1});
        check(dq_oe == 4'h0, "R4 read bus released", 32'(dq_oe), 0);
      end
      repeat (CYC - SAMP) @(negedge clk);
      check(cs_n && we_n && dq_oe == 4'h0 && addr == it.a, "R2 disable step", {cs_n, we_n, addr}, {2'b11, it.a});
      repeat (CYC) @(negedge clk);
    end
  endtask

  task automatic launch_run();
    push_all();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!fail && !done && busy, "R12 restart clears flags", {fail, done, busy}, 3'b001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) ram[i] = 4'h0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail, "R1 reset flags", {busy, done, fail}, 0);
    check(cs_n && we_n && dq_oe == 4'h0 && addr == 12'h0, "R1 reset bus", {cs_n, we_n, dq_oe, addr}, {2'b11, 16'h0});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Clean run with a start pulse mid-run
    launch_run();
    fork
      monitor();
      begin
        repeat (500) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    check(done && !busy, "R12 done after run", {done, busy}, 2'b10);
    check(!fail, "R11 clean run no fail", 32'(fail), 0);

    // Stuck bit at 0x00F (pass one) and 0x0FF (pass two)
    fault_en = 1'b1;
    launch_run();
    monitor();
    check(done, "R12 fault run completes", 32'(done), 1);
    check(fail, "R11 fail set", 32'(fail), 1);
    check(fail_addr == 12'h00F, "R11 first fail address", 32'(fail_addr), 32'h00F);
    check(fail_exp == 4'hF, "R11 first fail expected", 32'(fail_exp), 32'hF);
    check(fail_obs == 4'hB, "R11 first fail observed", 32'(fail_obs), 32'hB);

    // Pull-down: the deselect read must fail
    fault_en = 1'b0;
    pull_up  = 1'b0;
    launch_run();
    monitor();
    check(fail && fail_addr == 12'h000, "R10 deselect fail address", {fail, fail_addr}, {1'b1, 12'h000});
    check(fail_exp == 4'hF && fail_obs == 4'h0, "R10 deselect values", {fail_exp, fail_obs}, 8'hF0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule